// File: doc/BRIEF.md
# Dual-Clock FIFO Flag Controller

This block is a small first-in first-out buffer whose write side and read side run on unrelated clocks. Its job is to produce the status flags for both sides. The write and read pointers cross between the clock domains as Gray codes, each through a two-stage synchronizer. The data array is kept small and its depth is set by a parameter.

The block can present its flags in one of two ways. In standard mode the read-side flag reads high while words are stored, and a read takes one cycle to put the next word on `rdata`. The write-side flag reads high while there is free space. In fall-through mode the oldest word moves onto `rdata` by itself. In this mode the read-side flag goes low to say that a word is being presented. The write-side flag goes high when no more words can be accepted.

Two further flags report how full the buffer is: an almost-empty flag and an almost-full flag. Each compares the word count against a threshold. After a master reset, both thresholds come from one of four preset values. A serial load can then overwrite them. A partial reset empties the buffer but keeps the thresholds and the flag mode.

Top module: `xclk_flag_fifo`

## Requirements
- R1: In standard mode (`mode_fwft`=0 at master reset), `rd_flag` is 0 exactly when the buffer holds no word. A read request while `rd_flag` is 0 is ignored, and `rdata` keeps its previous value.
- R2: In standard mode, `wr_flag` is 0 when DEPTH words are stored. A write request while `wr_flag` is 0 is dropped, and the dropped word is never read out.
- R3: After a write into an empty buffer, `rd_flag` stays low through the first rising `rclk` edge after the write edge. It goes high at the second rising `rclk` edge after the write edge.
- R4: After a read frees space in a full buffer, the write-side flag stays unchanged through the first rising `wclk` edge after the read edge. It changes at the second rising `wclk` edge after the read edge.
- R5: In fall-through mode (`mode_fwft`=1), the oldest stored word appears on `rdata` without a read request, and `rd_flag` goes to 0 while a word is presented. A read request consumes the presented word. When nothing is presented, `rd_flag` is 1.
- R6: In fall-through mode, `wr_flag` is 1 when the array holds DEPTH words (DEPTH+1 words in total, counting the presented word), and writes are dropped while it is 1.
- R7: `almost_empty` is 1 exactly when the read-side word count is less than or equal to the almost-empty threshold.
- R8: `almost_full` is 1 exactly when DEPTH minus the write-side word count is less than or equal to the almost-full threshold.
- R9: While `mrst_n` is low, both thresholds are loaded with (`ofs_sel`+1)*DEPTH/8. With DEPTH=16 this gives 2, 4, 6 or 8.
- R10: A serial load takes 2*AW bits on `ser_din`, one per `wclk` edge while `ser_en` is 1. The almost-empty threshold comes first, most significant bit first, followed by the almost-full threshold. Both thresholds change only when the last bit arrives.
- R11: Master reset (`mrst_n` low) empties the buffer, clears `rdata` to 0, reloads the thresholds from the presets and samples `mode_fwft` again.
- R12: Partial reset (`prst_n` low) empties the buffer but keeps both thresholds and the flag mode.
- R13: In standard mode, words are returned in write order, and each word appears on `rdata` at the `rclk` edge that accepts the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock, also used to clock the serial threshold load |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| mode_fwft | input | 1 | Flag mode, sampled during master reset: 0 standard, 1 fall-through |
| ofs_sel | input | 2 | Preset threshold select, sampled during master reset |
| ser_en | input | 1 | Serial threshold load enable |
| ser_din | input | 1 | Serial threshold data |
| we | input | 1 | Write request |
| wdata | input | W | Write data |
| wr_flag | output | 1 | Write-side flag (meaning depends on the mode) |
| almost_full | output | 1 | Almost-full flag |
| re | input | 1 | Read request |
| rdata | output | W | Read data |
| rd_flag | output | 1 | Read-side flag (meaning depends on the mode) |
| almost_empty | output | 1 | Almost-empty flag |

## Verification
The assertions assume the following about the inputs:
- Each reset is held for several edges of both clocks.
- The flag mode and the thresholds stay quasi-static with respect to the read clock. The read domain takes them straight from write-clock registers.
- No serial load runs while the almost-empty result matters.

The stimulus keeps within these assumptions in three ways:
- Every input is driven on a falling edge of its own clock, and outputs are sampled half a nanosecond after the edges.
- The two clock periods are chosen so that no edge of one clock falls within that half nanosecond of an edge of the other.
- Every flag check after a change waits until both synchronizers have settled, except in the latency checks, which count the edges exactly.

// File: rtl/xclk_flag_fifo.sv
`timescale 1ns/100ps
module xclk_flag_fifo #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         mode_fwft,
  input  logic [1:0]   ofs_sel,
  input  logic         ser_en,
  input  logic         ser_din,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic         wr_flag,
  output logic         almost_full,
  input  logic         re,
  output logic [W-1:0] rdata,
  output logic         rd_flag,
  output logic         almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int SBITS = 2 * AW;
  localparam int CW    = $clog2(SBITS);

  function automatic logic [AW-1:0] preset(input logic [1:0] k);
    int v;
    v = ((int'(k) + 1) * DEPTH) / 8;
    if (v > DEPTH - 1) v = DEPTH - 1;
    return v[AW-1:0];
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic arst_n;
  assign arst_n = mrst_n & prst_n;

  // configuration: mode and thresholds, captured on wclk
  logic          fwft_q;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic [SBITS-1:0] shreg;
  logic [CW-1:0] scnt;
  logic [SBITS-1:0] shnext;
  assign shnext = {shreg[SBITS-2:0], ser_din};

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      fwft_q <= mode_fwft;
      ae_ofs <= preset(ofs_sel);
      af_ofs <= preset(ofs_sel);
      shreg  <= '0;
      scnt   <= '0;
    end else if (ser_en) begin
      shreg <= shnext;
      if (scnt == CW'(SBITS - 1)) begin
        scnt   <= '0;
        ae_ofs <= shnext[SBITS-1:AW];
        af_ofs <= shnext[AW-1:0];
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end

  // storage
  logic [W-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, rsync_bin, wused, wfree;
  logic wfull, wr_ok;
  logic [PW-1:0] rgray;

  assign rsync_bin = g2b(rg_s2);
  assign wused     = wbin - rsync_bin;
  assign wfull     = (wused == PW'(DEPTH));
  assign wr_ok     = we & ~wfull;
  assign wfree     = PW'(DEPTH) - wused;

  always_ff @(posedge wclk or negedge arst_n) begin
    if (!arst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_ok) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= wdata;

  assign wr_flag     = fwft_q ? wfull : ~wfull;
  assign almost_full = (wfree <= {1'b0, af_ofs});

  // read domain
  logic [PW-1:0] rbin, wg_s1, wg_s2, wsync_bin, core_cnt, rcount;
  logic core_empty, fetch, ov;
  logic [W-1:0] rdata_q;

  assign wsync_bin  = g2b(wg_s2);
  assign core_cnt   = wsync_bin - rbin;
  assign core_empty = (core_cnt == '0);
  assign fetch      = fwft_q ? (~core_empty & (~ov | re)) : (re & ~core_empty);
  assign rcount     = core_cnt + {{AW{1'b0}}, ov};

  always_ff @(posedge rclk or negedge arst_n) begin
    if (!arst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      ov      <= 1'b0;
      rdata_q <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (fetch) begin
        rbin    <= rbin + 1'b1;
        rgray   <= b2g(rbin + 1'b1);
        rdata_q <= mem[rbin[AW-1:0]];
      end
      if (fwft_q) begin
        if (fetch)   ov <= 1'b1;
        else if (re) ov <= 1'b0;
      end
    end
  end

  assign rdata        = rdata_q;
  assign rd_flag      = fwft_q ? ~ov : ~core_empty;
  assign almost_empty = (rcount <= {1'b0, ae_ofs});

  // assertions
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!arst_n)
    wused <= PW'(DEPTH));

  p_full_blocks_r2: assert property (@(posedge wclk) disable iff (!arst_n)
    (we && wfull) |=> $stable(wbin));

  p_empty_blocks_r1: assert property (@(posedge rclk) disable iff (!arst_n)
    (re && core_empty && !fwft_q) |=> ($stable(rbin) && $stable(rdata_q)));

  p_fwft_hold_r5: assert property (@(posedge rclk) disable iff (!arst_n)
    (fwft_q && ov && !re) |=> (ov && $stable(rdata_q)));

  p_ofs_hold_r12: assert property (@(posedge wclk) disable iff (!mrst_n)
    !ser_en |=> ($stable(ae_ofs) && $stable(af_ofs)));

  p_gray_step_r4: assert property (@(posedge wclk) disable iff (!arst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: tb/xclk_flag_fifo_tb_top.sv
`timescale 1ns/100ps
module xclk_flag_fifo_tb_top;
  localparam int W = 16, AW = 4, DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, mode_fwft = 0, ser_en = 0, ser_din = 0, we = 0, re = 0;
  logic [1:0] ofs_sel = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic wr_flag, almost_full, rd_flag, almost_empty;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  xclk_flag_fifo #(.W(W), .AW(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_fwft(mode_fwft),
    .ofs_sel(ofs_sel), .ser_en(ser_en), .ser_din(ser_din), .we(we), .wdata(wdata),
    .wr_flag(wr_flag), .almost_full(almost_full), .re(re), .rdata(rdata),
    .rd_flag(rd_flag), .almost_empty(almost_empty));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #0.5;
  endtask

  task automatic do_mreset(input logic fw, input logic [1:0] sel);
    @(negedge wclk);
    mrst_n = 0; we = 0; re = 0; ser_en = 0; mode_fwft = fw; ofs_sel = sel;
    repeat (3) @(posedge rclk);
    repeat (3) @(posedge wclk);
    @(negedge wclk) mrst_n = 1;
    settle();
  endtask

  task automatic do_preset();
    @(negedge wclk) prst_n = 0;
    repeat (3) @(posedge rclk);
    @(negedge wclk) prst_n = 1;
    settle();
  endtask

  task automatic wr(input logic [W-1:0] v);
    @(negedge wclk) begin we = 1; wdata = v; end
    @(negedge wclk) we = 0;
  endtask

  task automatic rd();
    @(negedge rclk) re = 1;
    @(negedge rclk) re = 0;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge wclk) begin ser_en = 1; ser_din = b; end
    @(negedge wclk) ser_en = 0;
  endtask

  task automatic t_reset_state();
    do_mreset(0, 0);
    chk("R1 empty after reset", rd_flag, 0);
    chk("R2 not full after reset", wr_flag, 1);
    chk("R11 rdata cleared", rdata, 0);
    chk("R7 almost_empty at reset", almost_empty, 1);
    chk("R8 almost_full at reset", almost_full, 0);
  endtask

  task automatic t_std_order();
    do_mreset(0, 0);
    wr(16'h00A1); wr(16'h00B2); wr(16'h00C3);
    settle();
    chk("R1 data present", rd_flag, 1);
    rd(); #0.5 chk("R13 first word", rdata, 16'h00A1);
    rd(); #0.5 chk("R13 second word", rdata, 16'h00B2);
    rd(); #0.5 chk("R13 third word", rdata, 16'h00C3);
    settle();
    chk("R1 empty after drain", rd_flag, 0);
    rd(); settle();
    chk("R1 read while empty ignored", rdata, 16'h00C3);
  endtask

  task automatic t_std_latency();
    do_mreset(0, 0);
    @(negedge wclk) begin we = 1; wdata = 16'h0055; end
    @(posedge wclk); #0.5 we = 0;
    chk("R3 low at write edge", rd_flag, 0);
    @(posedge rclk); #0.5 chk("R3 low after first rclk", rd_flag, 0);
    @(posedge rclk); #0.5 chk("R3 high after second rclk", rd_flag, 1);
  endtask

  task automatic t_std_full();
    do_mreset(0, 0);
    for (int i = 0; i < DEPTH; i++) wr(16'(i * 16'h111 + 1));
    settle();
    chk("R2 full flag", wr_flag, 0);
    wr(16'h0EEE);
    @(negedge rclk) re = 1;
    @(posedge rclk); #0.5 re = 0;
    chk("R13 head word", rdata, 16'h0001);
    chk("R4 still full at read edge", wr_flag, 0);
    @(posedge wclk); #0.5 chk("R4 full after first wclk", wr_flag, 0);
    @(posedge wclk); #0.5 chk("R4 space after second wclk", wr_flag, 1);
    for (int i = 1; i < DEPTH; i++) begin
      rd(); #0.5 chk("R2 drain order", rdata, 32'(16'(i * 16'h111 + 1)));
    end
    settle();
    chk("R2 dropped word absent", rd_flag, 0);
  endtask

  task automatic t_fwft();
    do_mreset(1, 0);
    chk("R5 nothing presented", rd_flag, 1);
    chk("R6 not full", wr_flag, 0);
    wr(16'h00A1);
    settle();
    chk("R5 word presented", rd_flag, 0);
    chk("R5 word falls through", rdata, 16'h00A1);
    for (int i = 0; i < DEPTH; i++) wr(16'(16'h100 + i));
    settle();
    chk("R6 full flag high", wr_flag, 1);
    wr(16'h0BAD);
    settle();
    chk("R5 first kept", rdata, 16'h00A1);
    rd(); #0.5;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5 fwft order", rdata, 32'(16'h100 + i));
      rd(); #0.5;
    end
    settle();
    chk("R6 dropped word absent", rd_flag, 1);
    wr(16'h0077);
    settle();
    do_preset();
    chk("R12 mode kept", rd_flag, 1);
    chk("R12 count cleared", almost_empty, 1);
  endtask

  task automatic t_almost();
    do_mreset(0, 1);
    for (int i = 0; i < 4; i++) wr(16'(i));
    settle();
    chk("R9 preset 4 almost_empty", almost_empty, 1);
    chk("R8 not almost_full", almost_full, 0);
    wr(16'h4);
    settle();
    chk("R7 above threshold", almost_empty, 0);
    for (int i = 0; i < 6; i++) wr(16'(i));
    settle();
    chk("R8 free 5", almost_full, 0);
    wr(16'h9);
    settle();
    chk("R8 free 4", almost_full, 1);
    rd();
    settle();
    chk("R8 free 5 again", almost_full, 0);
  endtask

  task automatic t_serial();
    logic [7:0] pat;
    do_mreset(0, 0);
    wr(16'h1); wr(16'h2);
    settle();
    chk("R9 preset 2 almost_empty", almost_empty, 1);
    pat = 8'b0001_0101;
    for (int i = 7; i > 0; i--) shift_bit(pat[i]);
    settle();
    chk("R10 before last bit", almost_empty, 1);
    shift_bit(pat[0]);
    settle();
    chk("R10 ae threshold loaded", almost_empty, 0);
    for (int i = 0; i < 9; i++) wr(16'(i));
    settle();
    chk("R10 af threshold loaded", almost_full, 1);
    do_preset();
    chk("R12 data cleared", rd_flag, 0);
    wr(16'h1);
    settle();
    chk("R12 ae kept at 1 word", almost_empty, 1);
    wr(16'h2);
    settle();
    chk("R12 ae kept at 2 words", almost_empty, 0);
    do_mreset(0, 3);
    chk("R11 empty after master reset", rd_flag, 0);
    wr(16'h1); wr(16'h2);
    settle();
    chk("R11 thresholds from preset 8", almost_empty, 1);
  endtask

  initial begin
    t_reset_state();
    t_std_order();
    t_std_latency();
    t_std_full();
    t_fwft();
    do_mreset(0, 0);
    chk("R11 mode resampled", rd_flag, 0);
    t_almost();
    t_serial();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule